// File: doc/BRIEF.md
# Serial DAC Write-Frame Receiver

This block takes 16-bit write frames from a three-wire serial link and turns them into register updates for a voltage-output converter. The link has an active-low frame select, a serial clock and a serial data line. All three are oversampled in one fast system clock domain. The block synchronises them, finds serial clock falling edges and frame-select transitions, and shifts data bits into a 16-bit word.

A completed word is split into a 2-bit operating-mode field and a 14-bit straight-binary code. The block then updates the held mode and code registers and pulses a one-cycle update strobe. A frame commits on its sixteenth serial clock falling edge, even if the frame select is still low. A frame that is cut short by the select rising early is discarded, and an abort pulse marks it.

Between frames the block measures how long the select stays high, counted in system clocks. A frame that starts before a parameterised minimum high time sets a sticky violation flag, and that frame is ignored.

Top module: `sdac_frame_rx`

## Requirements
- R1: While reset is held, and on leaving reset, the code output is 0, the mode output is 00, the power-down flag is 0, and the update strobe, the abort pulse and the violation flag are all low.
- R2: Bits are taken on serial clock falling edges while the select is low, most significant bit first. The first bit becomes mode bit 1 and the second becomes mode bit 0. Bits 3 to 16 become code bits 13 down to 0, so the last bit received is code bit 0.
- R3: On the sixteenth falling edge of a frame, the code and mode registers update while the select is still low. The update strobe is high for exactly one system clock for each committed frame.
- R4: If the select rises before the sixteenth falling edge, the frame is discarded and the abort output pulses for one cycle. Code and mode keep their values, and no update strobe is given.
- R5: Serial clock falling edges after the sixteenth, within the same low period of the select, cause no shifting and no further update.
- R6: Mode 00 is normal operation with the power-down flag at 0. Modes 01, 10 and 11 are three power-down modes. Each appears on the mode output, and the power-down flag is 1 for all three.
- R7: If the select falls after fewer than MIN_GAP_CLKS system clocks high, the violation flag sets and stays set until reset. That frame updates nothing.
- R8: If the select falls after at least MIN_GAP_CLKS clocks high, the frame is accepted normally. This holds even after the previous frame committed with the select held low.
- R9: Serial clock falling edges while the select is high change neither code nor mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst_n | input | 1 | Synchronous active-low reset |
| fsel_n_i | input | 1 | Active-low frame select (asynchronous) |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| sdat_i | input | 1 | Serial data (asynchronous) |
| dac_code_o | output | 14 | Held converter code |
| dac_mode_o | output | 2 | Held operating mode |
| pwr_down_o | output | 1 | High for any power-down mode |
| upd_stb_o | output | 1 | One-cycle pulse on each committed frame |
| abort_o | output | 1 | One-cycle pulse on each aborted frame |
| gap_viol_o | output | 1 | Sticky flag for a select high time that was too short |

## Verification
A wrong bit counter or state shows up at the ports within one frame. The code or mode outputs then change on the wrong edge, take shifted or misplaced bits, or change after an abort, an extra clock or an early select. A missing or doubled update strobe is visible within a few system clocks of the sixteenth edge. A fault in the gap timer shows as a violation flag set after a legal gap, or as a frame accepted after an illegal one. Either is seen on the first frame that follows the gap.

// File: rtl/sdac_pkg.sv
// Package: shared types and widths for the serial DAC frame receiver.
// Assumes one 16-bit frame: a 2-bit mode field followed by a 14-bit code.
package sdac_pkg;

    localparam int MODE_W  = 2;
    localparam int CODE_W  = 14;
    localparam int FRAME_W = MODE_W + CODE_W;

    typedef enum logic [MODE_W-1:0] {
        MODE_NORMAL = 2'b00,
        MODE_PD_A   = 2'b01,
        MODE_PD_B   = 2'b10,
        MODE_PD_C   = 2'b11
    } sdac_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SHIFT = 2'b01,
        ST_HELD  = 2'b10,
        ST_SKIP  = 2'b11
    } sdac_state_e;

    typedef struct packed {
        sdac_mode_e          mode;
        logic [CODE_W-1:0]   code;
    } sdac_frame_t;

endpackage

// File: rtl/sdac_edge_sync.sv
// Module: synchronises WIDTH asynchronous inputs through STAGES flops each,
// then gives the settled level and one-cycle rise and fall pulses.
// Assumes the inputs are idle high after reset (select and clock at rest).
module sdac_edge_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        // Shift the input through the synchroniser chain and keep the last level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '1;
                prev_q  <= 1'b1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[b]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        // Derive the level and the edge pulses from the settled value.
        always_comb begin
            level_o[b] = chain_q[STAGES-1];
            rise_o[b]  = chain_q[STAGES-1] & ~prev_q;
            fall_o[b]  = ~chain_q[STAGES-1] & prev_q;
        end
    end

endmodule

// File: rtl/sdac_gap_timer.sv
// Module: counts system clocks of frame-select high time and judges each
// select fall against MIN_GAP_CLKS. Keeps a sticky violation flag.
// Assumes the link is idle long enough at reset, so the counter starts saturated.
module sdac_gap_timer #(
    parameter int MIN_GAP_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_high_i,
    input  logic sel_fall_i,
    output logic gap_ok_o,
    output logic viol_o
);

    localparam int CNT_W = $clog2(MIN_GAP_CLKS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_GAP_CLKS);

    logic [CNT_W-1:0] high_cnt_q;
    logic             viol_q;

    // Count high cycles up to the minimum, and clear the count while the select is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_cnt_q <= CNT_MAX;
        end else if (!sel_high_i) begin
            high_cnt_q <= '0;
        end else if (high_cnt_q != CNT_MAX) begin
            high_cnt_q <= high_cnt_q + 1'b1;
        end
    end

    // Latch a violation when a frame starts before the minimum high time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
        end else if (sel_fall_i && (high_cnt_q != CNT_MAX)) begin
            viol_q <= 1'b1;
        end
    end

    assign gap_ok_o = (high_cnt_q == CNT_MAX);
    assign viol_o   = viol_q;

endmodule

// File: rtl/sdac_shift_core.sv
// Module: frame state machine and shift register. Captures bits on serial
// clock falls while a frame is open, commits on the FRAME_W-th fall, aborts on
// an early select rise, and ignores frames that started too early.
// Assumes edge pulses come from the same synchroniser, so data and clock line up.
module sdac_shift_core
    import sdac_pkg::*;
#(
    parameter int FRAME_BITS = FRAME_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_rise_i,
    input  logic                  sel_fall_i,
    input  logic                  sck_fall_i,
    input  logic                  sdat_i,
    input  logic                  gap_ok_i,
    output logic                  commit_o,
    output logic                  abort_o,
    output logic [FRAME_BITS-1:0] word_o
);

    localparam int BCNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(FRAME_BITS - 1);

    sdac_state_e           state_q;
    logic [FRAME_BITS-1:0] sreg_q;
    logic [BCNT_W-1:0]     bcnt_q;
    logic                  commit_q;
    logic                  abort_q;

    // Step the frame state, shift data bits in, and raise commit or abort pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            sreg_q   <= '0;
            bcnt_q   <= '0;
            commit_q <= 1'b0;
            abort_q  <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            abort_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (sel_fall_i) begin
                        sreg_q  <= '0;
                        bcnt_q  <= '0;
                        state_q <= gap_ok_i ? ST_SHIFT : ST_SKIP;
                    end
                end
                ST_SHIFT: begin
                    if (sel_rise_i) begin
                        sreg_q  <= '0;
                        bcnt_q  <= '0;
                        abort_q <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (sck_fall_i) begin
                        sreg_q <= {sreg_q[FRAME_BITS-2:0], sdat_i};
                        bcnt_q <= bcnt_q + 1'b1;
                        if (bcnt_q == LAST_BIT) begin
                            commit_q <= 1'b1;
                            state_q  <= ST_HELD;
                        end
                    end
                end
                ST_HELD, ST_SKIP: begin
                    if (sel_rise_i) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign commit_o = commit_q;
    assign abort_o  = abort_q;
    assign word_o   = sreg_q;

endmodule

// File: rtl/sdac_frame_rx.sv
// Module: top of the serial DAC write-frame receiver. Synchronises the link,
// times the select high gap, assembles frames and holds the mode and code.
// Assumes clk runs several times faster than the serial clock.
module sdac_frame_rx
    import sdac_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int MIN_GAP_CLKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsel_n_i,
    input  logic              sclk_i,
    input  logic              sdat_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic [MODE_W-1:0] dac_mode_o,
    output logic              pwr_down_o,
    output logic              upd_stb_o,
    output logic              abort_o,
    output logic              gap_viol_o
);

    localparam int IDX_SEL = 0;
    localparam int IDX_SCK = 1;
    localparam int IDX_DAT = 2;
    localparam int N_LINES = 3;

    logic [N_LINES-1:0] lvl, rise, fall;
    logic               gap_ok;
    logic               commit;
    logic [FRAME_W-1:0] word;
    sdac_frame_t        frame;
    sdac_frame_t        held_q;
    logic               stb_q;

    sdac_edge_sync #(
        .WIDTH  (N_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdat_i, sclk_i, fsel_n_i}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    sdac_gap_timer #(
        .MIN_GAP_CLKS (MIN_GAP_CLKS)
    ) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_high_i (lvl[IDX_SEL]),
        .sel_fall_i (fall[IDX_SEL]),
        .gap_ok_o   (gap_ok),
        .viol_o     (gap_viol_o)
    );

    sdac_shift_core #(
        .FRAME_BITS (FRAME_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_rise_i (rise[IDX_SEL]),
        .sel_fall_i (fall[IDX_SEL]),
        .sck_fall_i (fall[IDX_SCK]),
        .sdat_i     (lvl[IDX_DAT]),
        .gap_ok_i   (gap_ok),
        .commit_o   (commit),
        .abort_o    (abort_o),
        .word_o     (word)
    );

    assign frame = sdac_frame_t'(word);

    // Load the held mode and code on a committed frame and pulse the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '{mode: MODE_NORMAL, code: '0};
            stb_q  <= 1'b0;
        end else begin
            stb_q <= commit;
            if (commit) begin
                held_q <= frame;
            end
        end
    end

    assign dac_code_o = held_q.code;
    assign dac_mode_o = held_q.mode;
    assign pwr_down_o = (held_q.mode != MODE_NORMAL);
    assign upd_stb_o  = stb_q;

endmodule

// File: rtl/sdac_frame_rx_chk.sv
// Module: property checker for sdac_frame_rx, attached by bind below.
// Assumes it sees only the top-level ports.
module sdac_frame_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [13:0] dac_code_o,
    input logic [1:0]  dac_mode_o,
    input logic        upd_stb_o,
    input logic        abort_o,
    input logic        gap_viol_o
);

    // R1: the cycle after reset is sampled, the outputs are at rest.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (dac_code_o == '0 && dac_mode_o == '0 && !upd_stb_o && !gap_viol_o));

    // R3: the strobe lasts one cycle.
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb_o |=> !upd_stb_o);

    // R4: the code only moves together with a strobe.
    a_r4_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code_o) |-> upd_stb_o);

    // R4: the mode only moves together with a strobe.
    a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_mode_o) |-> upd_stb_o);

    // R4: an aborted frame never coincides with an update.
    a_r4_abort_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !upd_stb_o);

    // R7: the violation flag is sticky.
    a_r7_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        gap_viol_o |=> gap_viol_o);

endmodule

bind sdac_frame_rx sdac_frame_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dac_code_o (dac_code_o),
    .dac_mode_o (dac_mode_o),
    .upd_stb_o  (upd_stb_o),
    .abort_o    (abort_o),
    .gap_viol_o (gap_viol_o)
);

// File: tb/sdac_frame_rx_tb.sv
// Bench: directed tests for sdac_frame_rx, one task per scenario.
module sdac_frame_rx_tb;

    localparam int HALF = 4;
    localparam int IDLE = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsel_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdat = 1'b0;
    logic [13:0] code;
    logic [1:0]  mode;
    logic        pd, stb, abrt, viol;

    int n_tests = 0;
    int n_fail  = 0;
    int stb_cnt = 0;
    int abt_cnt = 0;
    bit done    = 1'b0;

    sdac_frame_rx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsel_n_i   (fsel_n),
        .sclk_i     (sclk),
        .sdat_i     (sdat),
        .dac_code_o (code),
        .dac_mode_o (mode),
        .pwr_down_o (pd),
        .upd_stb_o  (stb),
        .abort_o    (abrt),
        .gap_viol_o (viol)
    );

    always #4 clk = ~clk;

    // Count strobe and abort pulses, one per high cycle.
    always @(posedge clk) begin
        if (stb)  stb_cnt <= stb_cnt + 1;
        if (abrt) abt_cnt <= abt_cnt + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Open a frame, clock nbits out MSB first (bits past 16 are ones), optionally release.
    task automatic send(input logic [15:0] w, input int nbits, input bit rel);
        fsel_n = 1'b0;
        tick(6);
        for (int i = 0; i < nbits; i++) begin
            sdat = (i < 16) ? w[15-i] : 1'b1;
            tick(HALF);
            sclk = 1'b0;
            tick(HALF);
            sclk = 1'b1;
        end
        tick(8);
        if (rel) begin
            fsel_n = 1'b1;
            tick(IDLE);
        end
    endtask

    task automatic release_sel();
        fsel_n = 1'b1;
        tick(IDLE);
    endtask

    task automatic t_reset();
        chk(code == 0, "R1 code", code, 0);
        chk(mode == 0, "R1 mode", mode, 0);
        chk(!pd && !stb && !abrt && !viol, "R1 flags", {pd, stb, abrt, viol}, 0);
    endtask

    task automatic t_commit_low();
        int s0 = stb_cnt;
        send({2'b00, 14'h2A5C}, 16, 1'b0);
        chk(fsel_n == 1'b0 && code == 14'h2A5C, "R3 commit while select low", code, 14'h2A5C);
        chk(mode == 2'b00 && !pd, "R6 normal mode", {mode, pd}, 0);
        chk(stb_cnt - s0 == 1, "R3 one strobe", stb_cnt - s0, 1);
        release_sel();
    endtask

    task automatic t_bit_order();
        send({2'b10, 14'h0001}, 16, 1'b1);
        chk(code == 14'h0001, "R2 last bit is code bit 0", code, 1);
        chk(mode == 2'b10, "R2 first bit is mode bit 1", mode, 2);
        send({2'b00, 14'h3FFF}, 16, 1'b1);
        chk(code == 14'h3FFF, "R2 full-scale code", code, 14'h3FFF);
        send({2'b00, 14'h0000}, 16, 1'b1);
        chk(code == 14'h0000, "R2 zero code", code, 0);
    endtask

    task automatic t_modes();
        for (int m = 1; m < 4; m++) begin
            send({m[1:0], 14'h1234}, 16, 1'b1);
            chk(mode == m[1:0] && pd, "R6 power-down mode", {mode, pd}, {m[1:0], 1'b1});
        end
        send({2'b00, 14'h1234}, 16, 1'b1);
        chk(mode == 2'b00 && !pd, "R6 back to normal", {mode, pd}, 0);
    endtask

    task automatic t_abort();
        int s0 = stb_cnt;
        int a0 = abt_cnt;
        send({2'b11, 14'h3333}, 15, 1'b1);
        chk(code == 14'h1234 && mode == 2'b00, "R4 abort keeps code and mode", code, 14'h1234);
        chk(stb_cnt == s0, "R4 no strobe on abort", stb_cnt - s0, 0);
        chk(abt_cnt - a0 == 1, "R4 abort pulse", abt_cnt - a0, 1);
    endtask

    task automatic t_extra_clocks();
        int s0 = stb_cnt;
        send({2'b00, 14'h0F0F}, 20, 1'b0);
        chk(code == 14'h0F0F && mode == 2'b00, "R5 extra falls ignored", code, 14'h0F0F);
        chk(stb_cnt - s0 == 1, "R5 single strobe", stb_cnt - s0, 1);
        release_sel();
    endtask

    task automatic t_idle_clocks();
        for (int i = 0; i < 16; i++) begin
            sdat = 1'b1;
            tick(HALF);
            sclk = 1'b0;
            tick(HALF);
            sclk = 1'b1;
        end
        tick(8);
        chk(code == 14'h0F0F && mode == 2'b00, "R9 clocks with select high", code, 14'h0F0F);
    endtask

    task automatic t_gap();
        int s0;
        send({2'b00, 14'h0AAA}, 16, 1'b0);
        fsel_n = 1'b1;
        tick(2);
        s0 = stb_cnt;
        send({2'b01, 14'h0555}, 16, 1'b1);
        chk(viol == 1'b1, "R7 violation flag", viol, 1);
        chk(code == 14'h0AAA && mode == 2'b00 && stb_cnt == s0, "R7 early frame ignored", code, 14'h0AAA);
        send({2'b01, 14'h0555}, 16, 1'b1);
        chk(code == 14'h0555 && mode == 2'b01, "R8 frame after legal gap", code, 14'h0555);
        chk(viol == 1'b1, "R7 flag stays set", viol, 1);
    endtask

    initial begin
        tick(5);
        chk(code == 0 && !stb, "R1 during reset", code, 0);
        rst_n = 1'b1;
        tick(IDLE);
        t_reset();
        t_commit_low();
        t_bit_order();
        t_modes();
        t_abort();
        t_extra_clocks();
        t_idle_clocks();
        t_gap();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule